// File: doc/BRIEF.md
# Multicore external interrupt distributor

This block fans a set of level-sensitive external interrupt lines out to a group of processor cores. Software controls the fan-out through a small register space. There is a global enable mask and a global software-assert mask, each with its own clear address and set address. Each interrupt also has a routing word that holds one bit per core, so any interrupt can reach any subset of cores. Every core gets an output vector. The lowest three bits of that vector carry the core's inter-processor interrupt lines, which arrive from a neighbouring block. From bit 2 upward the vector carries the routed external interrupts.

The same register space also holds a run-stall register, whose bits drive one stall output per core. It also holds an identity word that tells a reader its own core index and the core count, and a one-bit control flag per core. Every register access carries the index of the requesting core. Reads return data one cycle after the request. Writes take effect at the next clock edge, and the output vectors follow the registered state combinationally.

Top module: `irq_distributor`

## Requirements
- R1: After reset: every enable bit is 1 for the configured interrupt count; the assert mask is 0; every routing word reads 0; `stall_out` has every bit set except bit 0; every per-core control flag is 0; `rd_data` is 0.
- R2: Until software writes a routing word, its interrupt is delivered to core 0 only. Writing the routing word for one interrupt ends this default for that interrupt alone.
- R3: For core c, output bits [N_IRQ+1:2] equal ((irq_in AND enable) OR assert) AND the set of interrupts routed to c, and bits [1:0] equal the core's IPI bits [1:0].
- R4: A write to offset 0x180 clears every enable bit written as 1. A write to 0x184 sets every enable bit written as 1. A read at 0x180 returns the enable mask.
- R5: Offsets 0x188 (clear) and 0x18C (set) act the same way on the assert mask, which is readable at 0x188. An asserted bit is active whatever `irq_in` holds and whatever the enable mask holds.
- R6: The routing word for interrupt i sits at offset i, for i below N_IRQ. Bit c of the word routes the interrupt to core c. A read at that offset returns the word.
- R7: A write to offset 0x200 loads the run-stall register from `wr_data[N_CORE-1:0]`. `stall_out` drives those bits from the next cycle, and a read at 0x200 returns them. Without such a write, `stall_out` holds its value.
- R8: A read at offset 0x1A0 returns ((N_CORE-1) << 18) | `req_core`.
- R9: A write to offset 0x220 stores `wr_data[0]` as the control flag of the requesting core only. A read at 0x220 returns the requester's flag in bit 0, with all other bits 0.
- R10: Reads at offsets not listed here return 0. This includes the set addresses 0x184 and 0x18C and routing offsets at or above N_IRQ. Writes to such offsets change no register and no output.
- R11: `rd_data` is loaded in the clock edge that samples `rd_en` and holds otherwise. A write changes the outputs only after the edge that samples it.
- R12: Each core's 3-bit IPI input is ORed into output bits [2:0]. Bit 2 is therefore shared with external interrupt 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | N_IRQ | External interrupt levels |
| ipi_in | input | 3*N_CORE | Per-core inter-processor interrupt lines, core c at [3c+2:3c] |
| req_core | input | CORE_W | Index of the core issuing the access |
| reg_addr | input | 10 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| core_irq | output | N_CORE*(N_IRQ+2) | Per-core interrupt vectors, core c at slice c |
| stall_out | output | N_CORE | Per-core stall levels |

## Verification
The output formula is swept over every value of `irq_in` under several configurations. The first uses the default routing right after reset, which shows that core 0 alone owns the interrupts. The next has part of the enable mask cleared, which shows that enable gating works. Then come mixed routing words that send each interrupt to a different set of cores, which exposes any mistake in how cores and interrupts are indexed. Last comes an assert mask with the inputs idle, which separates forcing from enabling. Every IPI value is also driven on every core to expose the sharing of bit 2. Register accesses from different requesting cores show whether the identity word and the control flags track the requester.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;
    localparam int REG_ADDR_W = 10;
    localparam int REG_DATA_W = 32;
    localparam int IPI_W      = 3;
    localparam int ID_SHIFT   = 18;

    localparam logic [REG_ADDR_W-1:0] OFS_EN_CLR = 10'h180;
    localparam logic [REG_ADDR_W-1:0] OFS_EN_SET = 10'h184;
    localparam logic [REG_ADDR_W-1:0] OFS_AS_CLR = 10'h188;
    localparam logic [REG_ADDR_W-1:0] OFS_AS_SET = 10'h18C;
    localparam logic [REG_ADDR_W-1:0] OFS_IDENT  = 10'h1A0;
    localparam logic [REG_ADDR_W-1:0] OFS_STALL  = 10'h200;
    localparam logic [REG_ADDR_W-1:0] OFS_CTRL   = 10'h220;

    // register target selected by an access
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ROUTE,
        SEL_EN_CLR,
        SEL_EN_SET,
        SEL_AS_CLR,
        SEL_AS_SET,
        SEL_IDENT,
        SEL_STALL,
        SEL_CTRL
    } reg_sel_e;
endpackage

// File: rtl/irq_dist_decode.sv
`timescale 1ns/1ps
module irq_dist_decode
    import irq_dist_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic [REG_ADDR_W-1:0] addr,
    output reg_sel_e              sel,
    output logic [IDX_W-1:0]      route_idx
);
    localparam logic [REG_ADDR_W-1:0] ROUTE_LIMIT = REG_ADDR_W'(N_IRQ);

    always_comb begin
        sel       = SEL_NONE;
        route_idx = '0;
        if (addr < ROUTE_LIMIT) begin
            sel       = SEL_ROUTE;
            route_idx = addr[IDX_W-1:0];
        end else begin
            unique case (addr)
                OFS_EN_CLR: sel = SEL_EN_CLR;
                OFS_EN_SET: sel = SEL_EN_SET;
                OFS_AS_CLR: sel = SEL_AS_CLR;
                OFS_AS_SET: sel = SEL_AS_SET;
                OFS_IDENT:  sel = SEL_IDENT;
                OFS_STALL:  sel = SEL_STALL;
                OFS_CTRL:   sel = SEL_CTRL;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_dist_mask.sv
`timescale 1ns/1ps
module irq_dist_mask #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_we,
    input  logic         set_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (clr_we) begin
            q <= q & ~bits;
        end else if (set_we) begin
            q <= q | bits;
        end
    end
endmodule

// File: rtl/irq_dist_route_tbl.sv
`timescale 1ns/1ps
module irq_dist_route_tbl #(
    parameter int N_CORE = 4,
    parameter int N_IRQ  = 8,
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [N_CORE-1:0]         wdata,
    output logic [N_CORE-1:0]         rd_word,
    output logic [N_CORE*N_IRQ-1:0]   core_map
);
    logic [N_CORE-1:0] route_q   [N_IRQ];
    logic [N_IRQ-1:0]  written_q;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                route_q[i]   <= '0;
                written_q[i] <= 1'b0;
            end else if (we && (idx == IDX_W'(i))) begin
                route_q[i]   <= wdata;
                written_q[i] <= 1'b1;
            end
        end

        // core 0 owns an interrupt until its word is written
        for (genvar c = 0; c < N_CORE; c++) begin : g_core
            assign core_map[c*N_IRQ + i] = written_q[i] ? route_q[i][c] : (c == 0);
        end
    end

    assign rd_word = route_q[idx];
endmodule

// File: rtl/irq_dist_fanout.sv
`timescale 1ns/1ps
module irq_dist_fanout
    import irq_dist_pkg::*;
#(
    parameter int N_IRQ = 8,
    localparam int OUT_W = N_IRQ + 2
) (
    input  logic [N_IRQ-1:0] active,
    input  logic [N_IRQ-1:0] routed,
    input  logic [IPI_W-1:0] ipi,
    output logic [OUT_W-1:0] vec
);
    logic [N_IRQ-1:0] ext;

    always_comb begin
        ext = active & routed;
        vec = {ext, 2'b00} | OUT_W'(ipi);
    end
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_IRQ  = 8,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int OUT_W  = N_IRQ + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_IRQ-1:0]          irq_in,
    input  logic [N_CORE*IPI_W-1:0]   ipi_in,
    input  logic [CORE_W-1:0]         req_core,
    input  logic [REG_ADDR_W-1:0]     reg_addr,
    input  logic                      wr_en,
    input  logic [REG_DATA_W-1:0]     wr_data,
    input  logic                      rd_en,
    output logic [REG_DATA_W-1:0]     rd_data,
    output logic [N_CORE*OUT_W-1:0]   core_irq,
    output logic [N_CORE-1:0]         stall_out
);
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam logic [N_IRQ-1:0]      EN_RST    = '1;
    localparam logic [N_CORE-1:0]     STALL_RST = ~N_CORE'(1);
    localparam logic [REG_DATA_W-1:0] ID_HI     = REG_DATA_W'(N_CORE - 1) << ID_SHIFT;

    reg_sel_e              sel;
    logic [IDX_W-1:0]      route_idx;
    logic [N_IRQ-1:0]      en_q;
    logic [N_IRQ-1:0]      as_q;
    logic [N_IRQ-1:0]      active;
    logic [N_CORE-1:0]     route_rd;
    logic [N_CORE*N_IRQ-1:0] core_map;
    logic [N_CORE-1:0]     stall_q;
    logic [N_CORE-1:0]     ctrl_q;
    logic [REG_DATA_W-1:0] rd_next;
    logic [REG_DATA_W-1:0] rd_q;
    logic                  unused_wdata;

    assign unused_wdata = ^wr_data;

    irq_dist_decode #(.N_IRQ(N_IRQ)) u_decode (
        .addr      (reg_addr),
        .sel       (sel),
        .route_idx (route_idx)
    );

    irq_dist_mask #(.W(N_IRQ), .RST_VAL(EN_RST)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .clr_we (wr_en && (sel == SEL_EN_CLR)),
        .set_we (wr_en && (sel == SEL_EN_SET)),
        .bits   (wr_data[N_IRQ-1:0]),
        .q      (en_q)
    );

    irq_dist_mask #(.W(N_IRQ), .RST_VAL('0)) u_force (
        .clk    (clk),
        .rst    (rst),
        .clr_we (wr_en && (sel == SEL_AS_CLR)),
        .set_we (wr_en && (sel == SEL_AS_SET)),
        .bits   (wr_data[N_IRQ-1:0]),
        .q      (as_q)
    );

    irq_dist_route_tbl #(.N_CORE(N_CORE), .N_IRQ(N_IRQ)) u_route (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en && (sel == SEL_ROUTE)),
        .idx      (route_idx),
        .wdata    (wr_data[N_CORE-1:0]),
        .rd_word  (route_rd),
        .core_map (core_map)
    );

    // stall and per-core control flags
    always_ff @(posedge clk) begin
        if (rst) begin
            stall_q <= STALL_RST;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_STALL: stall_q <= wr_data[N_CORE-1:0];
                SEL_CTRL:  ctrl_q[req_core] <= wr_data[0];
                default:   ;
            endcase
        end
    end

    assign stall_out = stall_q;

    // read selection
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_ROUTE:  rd_next[N_CORE-1:0] = route_rd;
            SEL_EN_CLR: rd_next[N_IRQ-1:0]  = en_q;
            SEL_AS_CLR: rd_next[N_IRQ-1:0]  = as_q;
            SEL_IDENT:  rd_next = ID_HI | REG_DATA_W'(req_core);
            SEL_STALL:  rd_next[N_CORE-1:0] = stall_q;
            SEL_CTRL:   rd_next[0] = ctrl_q[req_core];
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    // per-core output vectors
    assign active = (irq_in & en_q) | as_q;

    for (genvar c = 0; c < N_CORE; c++) begin : g_fan
        irq_dist_fanout #(.N_IRQ(N_IRQ)) u_fan (
            .active (active),
            .routed (core_map[c*N_IRQ +: N_IRQ]),
            .ipi    (ipi_in[c*IPI_W +: IPI_W]),
            .vec    (core_irq[c*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/irq_distributor_chk.sv
`timescale 1ns/1ps
module irq_distributor_chk
    import irq_dist_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_IRQ  = 8,
    localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1,
    localparam int OUT_W  = N_IRQ + 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [N_CORE*IPI_W-1:0] ipi_in,
    input logic [CORE_W-1:0]       req_core,
    input logic [REG_ADDR_W-1:0]   reg_addr,
    input logic                    wr_en,
    input logic [REG_DATA_W-1:0]   wr_data,
    input logic                    rd_en,
    input logic [REG_DATA_W-1:0]   rd_data,
    input logic [N_CORE*OUT_W-1:0] core_irq,
    input logic [N_CORE-1:0]       stall_out
);
    localparam logic [N_CORE-1:0]     STALL_RST = ~N_CORE'(1);
    localparam logic [REG_DATA_W-1:0] ID_HI     = REG_DATA_W'(N_CORE - 1) << ID_SHIFT;

    logic unused_chk;
    assign unused_chk = ^{wr_data, core_irq, ipi_in};

    p_stall_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> stall_out == STALL_RST);

    p_stall_load_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == OFS_STALL) |=> stall_out == $past(wr_data[N_CORE-1:0]));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && reg_addr == OFS_STALL) |=> $stable(stall_out));

    p_ident_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr == OFS_IDENT) |=> rd_data == (ID_HI | REG_DATA_W'($past(req_core))));

    p_set_addr_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (reg_addr == OFS_EN_SET || reg_addr == OFS_AS_SET)) |=> rd_data == '0);

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    for (genvar c = 0; c < N_CORE; c++) begin : g_ipi
        p_ipi_low_bits_r12: assert property (@(posedge clk) disable iff (rst)
            core_irq[c*OUT_W +: 2] == ipi_in[c*IPI_W +: 2]);
        p_ipi_bit2_r12: assert property (@(posedge clk) disable iff (rst)
            ipi_in[c*IPI_W + 2] |-> core_irq[c*OUT_W + 2]);
    end
endmodule

bind irq_distributor irq_distributor_chk #(.N_CORE(N_CORE), .N_IRQ(N_IRQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ipi_in    (ipi_in),
    .req_core  (req_core),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .core_irq  (core_irq),
    .stall_out (stall_out)
);

// File: tb/irq_distributor_test.sv
`timescale 1ns/1ps
module irq_distributor_test;
    localparam int NC = 4;
    localparam int NI = 8;
    localparam int OW = NI + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NI-1:0]   irq_in = '0;
    logic [NC*3-1:0] ipi_in = '0;
    logic [1:0]      req_core = '0;
    logic [9:0]      reg_addr = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic            rd_en = 1'b0;
    logic [31:0]     rd_data;
    logic [NC*OW-1:0] core_irq;
    logic [NC-1:0]   stall_out;

    int checks = 0;
    int errors = 0;

    // bench model of software-visible state
    logic [NI-1:0] m_en;
    logic [NI-1:0] m_as;
    logic [NC-1:0] m_route [NI];
    logic [NI-1:0] m_written;
    logic [NC-1:0] m_stall;
    logic [NC-1:0] m_ctrl;

    always #5 clk = ~clk;

    irq_distributor #(.N_CORE(NC), .N_IRQ(NI)) uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ipi_in(ipi_in),
        .req_core(req_core), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .core_irq(core_irq), .stall_out(stall_out)
    );

    function automatic logic [OW-1:0] exp_vec(input int c);
        logic [NI-1:0] ext = '0;
        for (int i = 0; i < NI; i++) begin
            logic routed = m_written[i] ? m_route[i][c] : (c == 0);
            if (routed && ((irq_in[i] && m_en[i]) || m_as[i])) ext[i] = 1'b1;
        end
        return {ext, 2'b00} | OW'(ipi_in[c*3 +: 3]);
    endfunction

    function automatic logic [31:0] exp_rd(input int core, input logic [9:0] a);
        if (a < 10'(NI)) return 32'(m_route[a[2:0]]);
        case (a)
            10'h180: return 32'(m_en);
            10'h188: return 32'(m_as);
            10'h1A0: return (32'(NC - 1) << 18) | 32'(core);
            10'h200: return 32'(m_stall);
            10'h220: return 32'(m_ctrl[core]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic check_cores(input string tag);
        for (int c = 0; c < NC; c++) begin
            checks++;
            if (core_irq[c*OW +: OW] !== exp_vec(c)) begin
                errors++;
                $display("FAIL %s core %0d in %h got %h exp %h", tag, c, irq_in,
                         core_irq[c*OW +: OW], exp_vec(c));
            end
        end
    endtask

    task automatic wr(input int core, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_core = core[1:0]; reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < 10'(NI)) begin
            m_route[a[2:0]] = d[NC-1:0];
            m_written[a[2:0]] = 1'b1;
        end else begin
            case (a)
                10'h180: m_en = m_en & ~d[NI-1:0];
                10'h184: m_en = m_en | d[NI-1:0];
                10'h188: m_as = m_as & ~d[NI-1:0];
                10'h18C: m_as = m_as | d[NI-1:0];
                10'h200: m_stall = d[NC-1:0];
                10'h220: m_ctrl[core] = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic rd(input int core, input logic [9:0] a, input string tag);
        @(negedge clk);
        req_core = core[1:0]; reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check32(tag, rd_data, exp_rd(core, a));
    endtask

    task automatic sweep(input string tag);
        for (int v = 0; v < (1 << NI); v++) begin
            @(negedge clk);
            irq_in = NI'(v);
            #1;
            check_cores(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_en = '1; m_as = '0; m_written = '0; m_stall = 4'b1110; m_ctrl = '0;
        for (int i = 0; i < NI; i++) m_route[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check32("R1 stall", 32'(stall_out), 32'h0000000E);
        check32("R1 rd_data", rd_data, 32'h0);
        rd(0, 10'h180, "R1 enable");
        rd(0, 10'h188, "R1 assert");
        rd(2, 10'h003, "R1 route word");
        rd(3, 10'h220, "R1 ctrl");

        // R2 default ownership by core 0, R3 formula
        sweep("R2 default routing");

        // R12 IPI sweep on every core
        irq_in = 8'h01;
        for (int c = 0; c < NC; c++) begin
            for (int v = 0; v < 8; v++) begin
                @(negedge clk);
                ipi_in = '0;
                ipi_in[c*3 +: 3] = 3'(v);
                #1;
                check_cores("R12 ipi");
            end
        end
        ipi_in = 12'h000;

        // R4 enable clear / set
        wr(1, 10'h180, 32'h0000000F);
        rd(1, 10'h180, "R4 enable after clear");
        sweep("R4 partial enable");
        wr(2, 10'h184, 32'h00000001);
        rd(0, 10'h180, "R4 enable after set");
        rd(0, 10'h184, "R10 enable set address reads 0");

        // R2 one word written, R6 routing words
        wr(0, 10'h002, 32'h0000000A);
        sweep("R2 single word written");
        for (int i = 0; i < NI; i++) wr(0, 10'(i), 32'((i * 5 + 3) & 15));
        rd(3, 10'h005, "R6 route readback");
        rd(1, 10'h007, "R6 route readback");
        ipi_in = 12'h924;
        sweep("R3 mixed routing");
        ipi_in = '0;

        // R5 assert mask forces lines
        wr(0, 10'h18C, 32'h00000081);
        rd(0, 10'h188, "R5 assert readback");
        rd(0, 10'h18C, "R10 assert set address reads 0");
        wr(0, 10'h180, 32'h000000FF);
        sweep("R5 forced with enable off");
        wr(0, 10'h188, 32'h00000001);
        wr(0, 10'h184, 32'h000000FF);
        sweep("R5 after assert clear");

        // R7 run-stall, R11 write timing
        @(negedge clk);
        req_core = 2'd0; reg_addr = 10'h200; wr_data = 32'h5; wr_en = 1'b1;
        #2;
        check32("R11 stall unchanged before edge", 32'(stall_out), 32'(m_stall));
        @(negedge clk);
        wr_en = 1'b0;
        m_stall = 4'h5;
        check32("R7 stall after write", 32'(stall_out), 32'h5);
        rd(2, 10'h200, "R7 stall readback");

        // R8 identity per requester
        for (int c = 0; c < NC; c++) rd(c, 10'h1A0, "R8 identity");

        // R9 per-core control
        wr(1, 10'h220, 32'hFFFFFFFE);
        rd(1, 10'h220, "R9 ctrl keeps bit 0 only");
        wr(1, 10'h220, 32'hFFFFFFFF);
        rd(1, 10'h220, "R9 ctrl set");
        rd(2, 10'h220, "R9 other core untouched");

        // R10 unknown offsets
        wr(0, 10'h3FC, 32'hFFFFFFFF);
        wr(0, 10'h008, 32'h00000000);
        wr(0, 10'h140, 32'hFFFFFFFF);
        rd(0, 10'h3FC, "R10 unknown read");
        rd(0, 10'h008, "R10 route beyond count");
        rd(0, 10'h180, "R10 enable intact");
        rd(0, 10'h188, "R10 assert intact");
        rd(0, 10'h200, "R10 stall intact");
        check32("R10 stall pins intact", 32'(stall_out), 32'h5);
        sweep("R10 outputs intact");

        // R11 read data holds without rd_en
        rd(3, 10'h1A0, "R11 read");
        repeat (3) @(negedge clk);
        check32("R11 rd_data holds", rd_data, (32'(NC - 1) << 18) | 32'd3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule